// File: doc/BRIEF.md
# Receive FIFO Host Service Controller

This block decides when the host should come and empty the 16-byte receive FIFO of a parallel port running in the reverse direction. It works from the FIFO occupancy count and two control bits supplied by software. With `dma_en` set and `svc_intr` clear, it requests DMA. It raises `dreq` while bytes are waiting and drops it when any of four things happens: the FIFO runs dry, a terminal count arrives on the last byte, software suspends the transfer, or the burst reaches its cycle limit. With `dma_en` clear, it requests programmed-I/O service through an interrupt instead.

Each way of stopping the request has its own rule for re-arming it. After the FIFO runs dry, the request comes back on the next byte with no software action. After a terminal count, the request waits until software has acknowledged the latched terminal-count interrupt by pulsing `svc_intr`. After a capped burst, the request waits until the DMA acknowledge has stayed inactive for a programmable hold-off time, counted in clock cycles. In programmed-I/O mode the interrupt fires once the FIFO holds at least `16 - min(thresh, 15)` bytes.

Top module: `hsc_fifo_service`

## Requirements
- R1: While `rst_n` is low and on its release, `dreq`, `intr` and `tc_irq` are all 0.
- R2: With `dma_en`=1 and `svc_intr`=0, an idle controller raises `dreq` on the clock edge after `fifo_count` becomes nonzero.
- R3: If `fifo_count` is 0 while `dreq` is high, `dreq` is low after the next edge. It rises again one edge after a byte is present, with no change of `svc_intr` needed.
- R4: A terminal count is taken only when `tc`=1 and `dack_n`=0 at a falling edge of `dack_n`, or at a falling edge of `rd_n` while `dack_n` is held low. It drops `dreq` on the next edge and sets `tc_irq`. A `tc` that arrives while `dack_n` is high has no effect.
- R5: After a terminal-count stop, `dreq` stays low even with bytes present until `svc_intr` has gone to 1 and back to 0. It rises on the second edge after `svc_intr` returns to 0.
- R6: `tc_irq` stays set until `svc_intr` is 1, and it then clears on the next edge. `intr` is high whenever `tc_irq` is.
- R7: Each falling edge of `dack_n` during a request counts one DMA cycle. On the 32nd such edge, `dreq` is low after that clock edge.
- R8: After a capped burst, `dreq` stays low until `dack_n` has been sampled high on `HOLD_CYC` = ceil(`HOLD_NS`/`CLK_PERIOD_NS`) consecutive edges, which is 18 with the default parameters. A low sample restarts the count. `dreq` rises one edge after the count completes.
- R9: The DMA cycle count clears whenever `dreq` is low, so each new request may run the full 32 cycles.
- R10: Setting `svc_intr`=1 or `dma_en`=0 drops `dreq` on the next edge. The request resumes one edge after both `dma_en`=1 and `svc_intr`=0 hold, provided bytes are present.
- R11: `intr` rises on the edge after `dma_en`=0, `svc_intr`=0 and `fifo_count` >= 16 - min(`thresh`, 15) all hold. It stays low if `svc_intr`=1 or `dma_en`=1 (no terminal count pending).
- R12: `thresh` values of 15, 16 and above all give a level of one byte.
- R13: `dreq` stays low while `dma_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_count | input | 5 | Bytes currently held in the receive FIFO (0 to 16) |
| dma_en | input | 1 | Selects DMA service (1) or programmed-I/O service (0) |
| svc_intr | input | 1 | Software mask: suspends service and acknowledges the terminal-count interrupt |
| thresh | input | 5 | Programmed-I/O threshold field |
| dack_n | input | 1 | DMA acknowledge, active low |
| rd_n | input | 1 | Host read strobe, active low |
| tc | input | 1 | Terminal count from the DMA controller |
| dreq | output | 1 | DMA request |
| intr | output | 1 | Service interrupt (threshold or terminal count) |
| tc_irq | output | 1 | Latched terminal-count interrupt |

## Verification
On every cycle the checker verifies the following: a request exists only when the preceding cycle permitted it, an empty FIFO or a qualified terminal count always ends the request, the burst counter never reaches the cap while the request is up, and the terminal-count latch both holds and clears as specified. It also checks the programmed-I/O threshold rule, including the saturated field values. The re-arm differences between the three stop causes cannot be seen in one-cycle properties. These are the wait for a `svc_intr` pulse after a terminal count, the restart of the hold-off window on a low acknowledge, and the fresh 32-cycle allowance after an empty stop, and the bench scenarios demonstrate them.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_REQ      = 2'd1,
    ST_TC_HOLD  = 2'd2,
    ST_CAP_HOLD = 2'd3
  } hsc_state_e;

  // Occupancy at which programmed-I/O service is wanted: the field counts
  // down from the depth and saturates one below it.
  function automatic int unsigned hsc_irq_level(input int unsigned thr,
                                                input int unsigned depth);
    int unsigned eff;
    eff = (thr > depth - 1) ? depth - 1 : thr;
    return depth - eff;
  endfunction

  // Whole clock cycles covering a time span, rounded up, at least one.
  function automatic int unsigned hsc_cycles(input int unsigned span_ns,
                                             input int unsigned period_ns);
    int unsigned c;
    c = (span_ns + period_ns - 1) / period_ns;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/hsc_edge_det.sv
module hsc_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strobe_n,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b1;
      else        prev_q[i] <= strobe_n[i];
    end
    assign fall[i] = prev_q[i] & ~strobe_n[i];
  end
endmodule

// File: rtl/hsc_dma_fsm.sv
module hsc_dma_fsm
  import hsc_pkg::*;
#(
  parameter int BURST_MAX = 32,
  parameter int HOLD_CYC  = 18,
  parameter int BC_W      = $clog2(BURST_MAX + 1),
  localparam int HC_W     = $clog2(HOLD_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dma_on,
  input  logic            fifo_nonempty,
  input  logic            tc_hit,
  input  logic            dack_fall,
  input  logic            dack_n,
  input  logic            rearm_ok,
  output logic            dreq,
  output logic [BC_W-1:0] burst_cnt
);
  hsc_state_e       state_q, state_d;
  logic [HC_W-1:0]  hold_cnt;
  logic             cap_hit;
  logic             hold_done;

  assign cap_hit   = (state_q == ST_REQ) && dack_fall &&
                     (burst_cnt == BC_W'(BURST_MAX - 1));
  assign hold_done = dack_n && (hold_cnt == HC_W'(HOLD_CYC - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (dma_on && fifo_nonempty) state_d = ST_REQ;
      ST_REQ: begin
        if (!dma_on)             state_d = ST_IDLE;
        else if (tc_hit)         state_d = ST_TC_HOLD;
        else if (cap_hit)        state_d = ST_CAP_HOLD;
        else if (!fifo_nonempty) state_d = ST_IDLE;
      end
      ST_TC_HOLD:  if (rearm_ok)  state_d = ST_IDLE;
      ST_CAP_HOLD: if (hold_done) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || state_q != ST_REQ) burst_cnt <= '0;
    else if (dack_fall)              burst_cnt <= burst_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || state_q != ST_CAP_HOLD || !dack_n) hold_cnt <= '0;
    else if (!hold_done)                             hold_cnt <= hold_cnt + 1'b1;
  end

  assign dreq = (state_q == ST_REQ);
endmodule

// File: rtl/hsc_irq_unit.sv
module hsc_irq_unit
  import hsc_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int THR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_en,
  input  logic             svc_intr,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [THR_W-1:0] thresh,
  input  logic             tc_hit,
  output logic             intr,
  output logic             tc_irq
);
  logic pio_hit;
  logic tc_irq_d;

  assign pio_hit  = !dma_en && !svc_intr &&
                    (32'(fifo_count) >= hsc_irq_level(32'(thresh), FIFO_DEPTH));
  assign tc_irq_d = svc_intr ? 1'b0 : (tc_irq | tc_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc_irq <= 1'b0;
      intr   <= 1'b0;
    end else begin
      tc_irq <= tc_irq_d;
      intr   <= pio_hit | tc_irq_d;
    end
  end
endmodule

// File: rtl/hsc_fifo_service.sv
module hsc_fifo_service
  import hsc_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH    = 16,
  parameter int          BURST_MAX     = 32,
  parameter int unsigned HOLD_NS       = 350,
  parameter int unsigned CLK_PERIOD_NS = 20,
  localparam int CNT_W    = $clog2(FIFO_DEPTH + 1),
  localparam int THR_W    = $clog2(FIFO_DEPTH) + 1,
  localparam int BC_W     = $clog2(BURST_MAX + 1),
  localparam int HOLD_CYC = int'(hsc_cycles(HOLD_NS, CLK_PERIOD_NS))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             dma_en,
  input  logic             svc_intr,
  input  logic [THR_W-1:0] thresh,
  input  logic             dack_n,
  input  logic             rd_n,
  input  logic             tc,
  output logic             dreq,
  output logic             intr,
  output logic             tc_irq
);
  logic [1:0]      falls;
  logic            dack_fall;
  logic            rd_fall;
  logic            tc_hit;
  logic [BC_W-1:0] burst_cnt;

  hsc_edge_det #(.N(2)) u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n ({rd_n, dack_n}),
    .fall     (falls)
  );
  assign dack_fall = falls[0];
  assign rd_fall   = falls[1];

  // Last-byte event: terminal count while acknowledged, taken on the
  // acknowledge edge or, lacking one, on the read strobe edge.
  assign tc_hit = dma_en && tc && !dack_n && (dack_fall || rd_fall);

  hsc_dma_fsm #(
    .BURST_MAX (BURST_MAX),
    .HOLD_CYC  (HOLD_CYC),
    .BC_W      (BC_W)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .dma_on        (dma_en && !svc_intr),
    .fifo_nonempty (fifo_count != '0),
    .tc_hit        (tc_hit),
    .dack_fall     (dack_fall),
    .dack_n        (dack_n),
    .rearm_ok      (!tc_irq && !svc_intr),
    .dreq          (dreq),
    .burst_cnt     (burst_cnt)
  );

  hsc_irq_unit #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W),
    .THR_W      (THR_W)
  ) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_en     (dma_en),
    .svc_intr   (svc_intr),
    .fifo_count (fifo_count),
    .thresh     (thresh),
    .tc_hit     (tc_hit),
    .intr       (intr),
    .tc_irq     (tc_irq)
  );
endmodule

// File: rtl/hsc_fifo_service_chk.sv
module hsc_fifo_service_chk
  import hsc_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int BURST_MAX = 32,
  parameter int CNT_W = 5,
  parameter int THR_W = 5,
  parameter int BC_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] fifo_count,
  input logic             dma_en,
  input logic             svc_intr,
  input logic [THR_W-1:0] thresh,
  input logic             dreq,
  input logic             intr,
  input logic             tc_irq,
  input logic             tc_hit,
  input logic [BC_W-1:0]  burst_cnt
);
  AST_DREQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> $past(dma_en && !svc_intr)); // R10
  AST_EMPTY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && fifo_count == '0) |=> !dreq); // R3
  AST_TC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && tc_hit && !svc_intr) |=> (!dreq && tc_irq)); // R4
  AST_TC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_irq && !svc_intr) |=> tc_irq); // R6
  AST_TC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    svc_intr |=> !tc_irq); // R6
  AST_TC_INTR: assert property (@(posedge clk) disable iff (!rst_n)
    tc_irq |-> intr); // R6
  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> (32'(burst_cnt) < 32'(BURST_MAX))); // R7
  AST_NO_DREQ_PIO: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> !dreq); // R13
  AST_PIO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && !svc_intr &&
     32'(fifo_count) >= hsc_irq_level(32'(thresh), FIFO_DEPTH)) |=> intr); // R11
  AST_THR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && !svc_intr && 32'(thresh) >= FIFO_DEPTH - 1 &&
     fifo_count != '0) |=> intr); // R12
endmodule

bind hsc_fifo_service hsc_fifo_service_chk #(
  .FIFO_DEPTH (FIFO_DEPTH),
  .BURST_MAX  (BURST_MAX),
  .CNT_W      (CNT_W),
  .THR_W      (THR_W),
  .BC_W       (BC_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_count (fifo_count),
  .dma_en     (dma_en),
  .svc_intr   (svc_intr),
  .thresh     (thresh),
  .dreq       (dreq),
  .intr       (intr),
  .tc_irq     (tc_irq),
  .tc_hit     (tc_hit),
  .burst_cnt  (burst_cnt)
);

// File: tb/hsc_fifo_service_tb.sv
`timescale 1ns/1ps
module hsc_fifo_service_tb;
  localparam int CLK_PERIOD = 20;
  localparam int HOLD_NS    = 350;
  localparam int HOLD       = (HOLD_NS + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int NV         = 13;
  // {thresh[4:0], count[4:0], svc_intr, expected intr}
  localparam logic [11:0] VEC [NV] = '{
    {5'd12, 5'd4,  1'b0, 1'b1},
    {5'd12, 5'd3,  1'b0, 1'b0},
    {5'd12, 5'd16, 1'b0, 1'b1},
    {5'd0,  5'd15, 1'b0, 1'b0},
    {5'd0,  5'd16, 1'b0, 1'b1},
    {5'd15, 5'd1,  1'b0, 1'b1},
    {5'd15, 5'd0,  1'b0, 1'b0},
    {5'd16, 5'd1,  1'b0, 1'b1},
    {5'd16, 5'd0,  1'b0, 1'b0},
    {5'd31, 5'd1,  1'b0, 1'b1},
    {5'd8,  5'd8,  1'b0, 1'b1},
    {5'd8,  5'd7,  1'b0, 1'b0},
    {5'd12, 5'd10, 1'b1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] fifo_count = '0;
  logic       dma_en = 1'b0, svc_intr = 1'b0;
  logic [4:0] thresh = '0;
  logic       dack_n = 1'b1, rd_n = 1'b1, tc = 1'b0;
  logic       dreq, intr, tc_irq;
  int         n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsc_fifo_service #(.HOLD_NS(HOLD_NS), .CLK_PERIOD_NS(CLK_PERIOD)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_count(fifo_count), .dma_en(dma_en),
    .svc_intr(svc_intr), .thresh(thresh), .dack_n(dack_n), .rd_n(rd_n),
    .tc(tc), .dreq(dreq), .intr(intr), .tc_irq(tc_irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick();
    chk("R1 dreq in reset", dreq, 1'b0);
    chk("R1 intr in reset", intr, 1'b0);
    chk("R1 tc_irq in reset", tc_irq, 1'b0);
    rst_n = 1'b1;
    tick();
    chk("R1 dreq after release", dreq, 1'b0);

    // Programmed-I/O threshold table: R11, R12, R13
    for (int i = 0; i < NV; i++) begin
      thresh     = VEC[i][11:7];
      fifo_count = VEC[i][6:2];
      svc_intr   = VEC[i][1];
      tick();
      chk("R11/R12 pio intr", intr, VEC[i][0]);
      chk("R13 no dreq in pio", dreq, 1'b0);
    end

    // R2 / R11: DMA start, no pio interrupt in DMA mode
    svc_intr = 1'b0; thresh = 5'd15; fifo_count = '0; dma_en = 1'b1;
    tick();
    chk("R2 idle with empty fifo", dreq, 1'b0);
    fifo_count = 5'd3;
    tick();
    chk("R2 dreq on data", dreq, 1'b1);
    chk("R11 no pio intr in dma", intr, 1'b0);
    dack_n = 1'b0; tick(); dack_n = 1'b1; tick();
    chk("R2 dreq holds with data", dreq, 1'b1);

    // R3: empty stop and self re-arm
    fifo_count = '0;
    tick();
    chk("R3 drop on empty", dreq, 1'b0);
    fifo_count = 5'd1;
    tick();
    chk("R3 re-arm on byte", dreq, 1'b1);

    // R9 / R7: fresh 32-cycle allowance, cap on the 32nd
    for (int k = 0; k < 31; k++) begin
      dack_n = 1'b0; tick(); dack_n = 1'b1; tick();
    end
    chk("R9 counter cleared at restart", dreq, 1'b1);
    dack_n = 1'b0;
    tick();
    chk("R7 cap on 32nd cycle", dreq, 1'b0);

    // R8: hold-off with restart on a low acknowledge
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R8 low while ack active", dreq, 1'b0);
    end
    dack_n = 1'b1;
    for (int k = 0; k < HOLD - 1; k++) begin
      tick();
      chk("R8 low inside hold-off", dreq, 1'b0);
    end
    dack_n = 1'b0;
    tick();
    chk("R8 low on ack glitch", dreq, 1'b0);
    dack_n = 1'b1;
    for (int k = 0; k < HOLD; k++) begin
      tick();
      chk("R8 hold-off restarted", dreq, 1'b0);
    end
    tick();
    chk("R8 re-arm after hold-off", dreq, 1'b1);

    // R4: unqualified tc ignored, qualified tc stops
    tc = 1'b1;
    tick();
    chk("R4 tc without ack ignored dreq", dreq, 1'b1);
    chk("R4 tc without ack ignored irq", tc_irq, 1'b0);
    dack_n = 1'b0;
    tick();
    chk("R4 tc on ack edge drops dreq", dreq, 1'b0);
    chk("R4 tc latches irq", tc_irq, 1'b1);
    chk("R6 intr with tc", intr, 1'b1);
    tc = 1'b0; dack_n = 1'b1; fifo_count = 5'd5;

    // R5 / R6: wait for svc_intr pulse
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R5 no re-arm with bytes", dreq, 1'b0);
      chk("R6 tc_irq held", tc_irq, 1'b1);
    end
    svc_intr = 1'b1;
    tick();
    chk("R6 tc_irq cleared", tc_irq, 1'b0);
    chk("R6 intr cleared", intr, 1'b0);
    svc_intr = 1'b0;
    tick();
    chk("R5 one edge after svc low", dreq, 1'b0);
    tick();
    chk("R5 re-arm after svc pulse", dreq, 1'b1);

    // R4: tc on read strobe with ack held low
    dack_n = 1'b0;
    tick();
    chk("R4 ack edge without tc keeps dreq", dreq, 1'b1);
    tc = 1'b1; rd_n = 1'b0;
    tick();
    chk("R4 tc on read strobe drops dreq", dreq, 1'b0);
    chk("R4 tc on read strobe latches irq", tc_irq, 1'b1);
    tc = 1'b0; rd_n = 1'b1; dack_n = 1'b1; svc_intr = 1'b1;
    tick();
    svc_intr = 1'b0;
    tick(); tick();
    chk("R5 re-arm after read strobe tc", dreq, 1'b1);

    // R10: suspend and resume
    svc_intr = 1'b1;
    tick();
    chk("R10 svc_intr drops dreq", dreq, 1'b0);
    dma_en = 1'b0;
    tick();
    dma_en = 1'b1;
    tick();
    chk("R10 stays low until svc clear", dreq, 1'b0);
    svc_intr = 1'b0;
    tick();
    chk("R10 resume", dreq, 1'b1);
    dma_en = 1'b0;
    tick();
    chk("R10 dma_en low drops dreq", dreq, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule